// File: doc/BRIEF.md
# Up/Down Auto-Reload Timer

This block is a 16-bit timer/counter with a 16-bit reload register. While its run control is set, each qualifying tick moves the count by one. A tick comes either from an internal timer clock-enable or from falling edges on an external count pin. A select input chooses between the two sources. When the count wraps, the timer loads a fresh value, sets a sticky overflow flag and sends a one-cycle interrupt request.

With the up/down enable clear, the timer only counts up. On leaving the all-ones value it restarts from the reload register. With the up/down enable set, a direction pin chooses the direction. Counting up behaves as before. Counting down treats the reload value as the floor: when the count has come down to it, the next tick loads all ones. In this mode an extension bit flips on every wrap, which adds a seventeenth bit of resolution without a second interrupt. Software loads the count and reload registers through byte-lane write strobes and reads both back on output buses.

The count pin and the direction pin are asynchronous. Each passes through a two-flop synchroniser before it is used.

Top module: `updn_reload_timer`

## Requirements
- R1: After a synchronous reset, the count, reload value, overflow flag, extension bit and interrupt request all read zero.
- R2: A qualifying tick advances the count by one only while `run` is high. With `run` low, or with no tick, the count holds.
- R3: With `dn_en` low, the timer counts up whatever the direction pin shows. A tick at count 0xFFFF loads the reload value and sets the overflow flag.
- R4: With `dn_en` high and the synchronised direction pin high (1 = up), the timer counts up. It wraps from 0xFFFF to the reload value, and every such wrap inverts `ext_o`. With `dn_en` low, `ext_o` never changes.
- R5: With `dn_en` high and the synchronised direction pin low (0 = down), each tick decrements the count. Passing through zero (0x0000 to 0xFFFF) is not a wrap. A tick while the count equals the reload value loads 0xFFFF, sets the flag and inverts `ext_o`.
- R6: `irq_o` is high for exactly the one cycle after each wrap, and it is never high while the flag is clear.
- R7: The overflow flag stays set until `flag_clr` is asserted. If a wrap and `flag_clr` fall in the same cycle, the flag ends set.
- R8: `cnt_we` bit 0 writes count bits 7:0 and bit 1 writes bits 15:8, both from the matching `wdata` lane. In any cycle with a count write, a tick is discarded: there is no step and no wrap.
- R9: `rld_we` bit 0 and bit 1 load reload bits 7:0 and 15:8 from `wdata`. `reload_o` shows the register. A down-count comparison in the same cycle uses the old value.
- R10: With `sel_ext` high, `int_tick` is ignored. Only a falling edge of `cnt_pin` counts, and it advances the count one time, within three clock edges after the fall. Rising edges and a steady level do not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| int_tick | input | 1 | Internal timer clock-enable |
| cnt_pin | input | 1 | Asynchronous external count pin |
| dir_pin | input | 1 | Asynchronous direction pin, 1 = up |
| sel_ext | input | 1 | Tick source: 0 internal, 1 count pin |
| run | input | 1 | Run control |
| dn_en | input | 1 | Up/down mode enable |
| cnt_we | input | 2 | Count byte-lane write strobes |
| rld_we | input | 2 | Reload byte-lane write strobes |
| wdata | input | 16 | Write data for both registers |
| flag_clr | input | 1 | Clears the overflow flag |
| count_o | output | 16 | Current count |
| reload_o | output | 16 | Reload register |
| ovf_flag_o | output | 1 | Sticky overflow/underflow flag |
| ext_o | output | 1 | Extension bit, inverted per wrap in up/down mode |
| irq_o | output | 1 | One-cycle interrupt request per wrap |

## Verification
Some rules can be judged one cycle at a time, and the assertions check these on every cycle:
- the single increment, and the hold while stopped;
- the wrap targets in both directions;
- the lane writes and their priority over a tick;
- the flag's stickiness;
- the extension bit staying still outside up/down mode;
- the single-cycle count pulse out of the synchroniser.

Other behaviour depends on how a sequence unfolds, and only the bench scenarios show it:
- the full countdown through zero to the reload floor;
- a clear arriving in the same cycle as a wrap;
- the old reload value being used in a same-cycle compare;
- external counting of whole pin pulses while the internal tick is ignored.

// File: rtl/urt_pkg.sv
`timescale 1ns/1ps
package urt_pkg;

  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } dir_e;

  typedef struct packed {
    logic hit;   // a wrap happens on this tick
    dir_e dir;   // direction in force for the tick
  } wrap_t;

endpackage

// File: rtl/urt_pin_sync.sv
`timescale 1ns/1ps
module urt_pin_sync #(
  parameter int               NPINS     = 2,
  parameter int               STAGES    = 2,
  parameter logic [NPINS-1:0] FALL_MASK = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pin_i,
  output logic [NPINS-1:0] sync_o
);

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    logic [STAGES-1:0] chain_q;
    logic              level;

    always_ff @(posedge clk) begin
      if (rst) chain_q <= '0;
      else     chain_q <= {chain_q[STAGES-2:0], pin_i[g]};
    end
    assign level = chain_q[STAGES-1];

    if (FALL_MASK[g]) begin : g_fall
      logic prev_q;
      always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= level;
      end
      assign sync_o[g] = prev_q & ~level;

      // a detected fall lasts one cycle only
      p_fall_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        sync_o[g] |=> !sync_o[g]);
    end else begin : g_level
      assign sync_o[g] = level;
    end
  end

endmodule

// File: rtl/urt_reload_reg.sv
`timescale 1ns/1ps
module urt_reload_reg #(
  parameter  int WIDTH  = 16,
  parameter  int LANE   = 8,
  localparam int NLANES = WIDTH / LANE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NLANES-1:0] we,
  input  logic [WIDTH-1:0]  wdata,
  output logic [WIDTH-1:0]  value_o
);

  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    logic [LANE-1:0] lane_q;

    always_ff @(posedge clk) begin
      if (rst)        lane_q <= '0;
      else if (we[g]) lane_q <= wdata[g*LANE +: LANE];
    end
    assign value_o[g*LANE +: LANE] = lane_q;

    p_lane_write_r9: assert property (@(posedge clk) disable iff (rst)
      we[g] |=> value_o[g*LANE +: LANE] == $past(wdata[g*LANE +: LANE]));
    p_lane_hold_r9: assert property (@(posedge clk) disable iff (rst)
      !we[g] |=> $stable(value_o[g*LANE +: LANE]));
  end

endmodule

// File: rtl/urt_count_core.sv
`timescale 1ns/1ps
module urt_count_core
  import urt_pkg::*;
#(
  parameter  int WIDTH  = 16,
  parameter  int LANE   = 8,
  localparam int NLANES = WIDTH / LANE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              run,
  input  logic              dn_en,
  input  logic              dir_up,
  input  logic [NLANES-1:0] cnt_we,
  input  logic [WIDTH-1:0]  wdata,
  input  logic [WIDTH-1:0]  reload,
  input  logic              flag_clr,
  output logic [WIDTH-1:0]  count_o,
  output logic              flag_o,
  output logic              ext_o,
  output logic              irq_o
);

  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  logic [WIDTH-1:0] count_q, count_d, merged;
  logic             flag_q, ext_q, irq_q;
  logic             any_we, step;
  wrap_t            wr;

  // byte-lane merge of a software write into the count
  for (genvar g = 0; g < NLANES; g++) begin : g_merge
    assign merged[g*LANE +: LANE] = cnt_we[g] ? wdata[g*LANE +: LANE]
                                              : count_q[g*LANE +: LANE];
  end

  always_comb begin
    any_we = |cnt_we;
    step   = run & tick & ~any_we;
    wr.dir = (!dn_en || dir_up) ? DIR_UP : DIR_DOWN;
    wr.hit = step & ((wr.dir == DIR_UP) ? (count_q == ALL_ONES)
                                        : (count_q == reload));
    if (any_we)
      count_d = merged;
    else if (wr.hit)
      count_d = (wr.dir == DIR_UP) ? reload : ALL_ONES;
    else if (step)
      count_d = (wr.dir == DIR_UP) ? count_q + 1'b1 : count_q - 1'b1;
    else
      count_d = count_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      flag_q  <= 1'b0;
      ext_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      count_q <= count_d;
      irq_q   <= wr.hit;
      if (wr.hit)        flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
      if (wr.hit && dn_en) ext_q <= ~ext_q;
    end
  end

  assign count_o = count_q;
  assign flag_o  = flag_q;
  assign ext_o   = ext_q;
  assign irq_o   = irq_q;

  // R2: no step without run and tick
  p_hold_stopped_r2: assert property (@(posedge clk) disable iff (rst)
    (!(run && tick) && cnt_we == '0) |=> $stable(count_q));
  p_single_step_r2: assert property (@(posedge clk) disable iff (rst)
    (run && tick && cnt_we == '0 && (!dn_en || dir_up) && count_q != ALL_ONES)
    |=> count_q == WIDTH'($past(count_q) + 1'b1));
  // R3: up wrap loads the reload value and flags
  p_up_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (run && tick && cnt_we == '0 && (!dn_en || dir_up) && count_q == ALL_ONES)
    |=> (count_q == $past(reload)) && flag_q);
  // R5: down wrap at the reload floor loads all ones
  p_down_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    (run && tick && cnt_we == '0 && dn_en && !dir_up && count_q == reload)
    |=> (count_q == ALL_ONES) && flag_q);
  // R4: extension bit moves only on up/down-mode steps
  p_ext_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    !(run && tick && cnt_we == '0 && dn_en) |=> $stable(ext_q));
  // R6: request only with the flag up
  p_irq_flag_r6: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> flag_q);
  // R7: flag sticky until cleared
  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !flag_clr) |=> flag_q);
  // R8: written lanes take the write data
  for (genvar g = 0; g < NLANES; g++) begin : g_wchk
    p_write_lane_r8: assert property (@(posedge clk) disable iff (rst)
      cnt_we[g] |=> count_q[g*LANE +: LANE] == $past(wdata[g*LANE +: LANE]));
  end

endmodule

// File: rtl/updn_reload_timer.sv
`timescale 1ns/1ps
module updn_reload_timer #(
  parameter  int WIDTH       = 16,
  parameter  int LANE        = 8,
  parameter  int SYNC_STAGES = 2,
  localparam int NLANES      = WIDTH / LANE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              int_tick,
  input  logic              cnt_pin,
  input  logic              dir_pin,
  input  logic              sel_ext,
  input  logic              run,
  input  logic              dn_en,
  input  logic [NLANES-1:0] cnt_we,
  input  logic [NLANES-1:0] rld_we,
  input  logic [WIDTH-1:0]  wdata,
  input  logic              flag_clr,
  output logic [WIDTH-1:0]  count_o,
  output logic [WIDTH-1:0]  reload_o,
  output logic              ovf_flag_o,
  output logic              ext_o,
  output logic              irq_o
);

  // pin 0: count pin (fall detect), pin 1: direction level
  logic [1:0]       pins_s;
  logic [WIDTH-1:0] reload;
  logic             tick_sel;

  urt_pin_sync #(
    .NPINS    (2),
    .STAGES   (SYNC_STAGES),
    .FALL_MASK(2'b01)
  ) u_sync (
    .clk   (clk),
    .rst   (rst),
    .pin_i ({dir_pin, cnt_pin}),
    .sync_o(pins_s)
  );

  assign tick_sel = sel_ext ? pins_s[0] : int_tick;

  urt_reload_reg #(
    .WIDTH(WIDTH),
    .LANE (LANE)
  ) u_reload (
    .clk    (clk),
    .rst    (rst),
    .we     (rld_we),
    .wdata  (wdata),
    .value_o(reload)
  );

  urt_count_core #(
    .WIDTH(WIDTH),
    .LANE (LANE)
  ) u_core (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick_sel),
    .run     (run),
    .dn_en   (dn_en),
    .dir_up  (pins_s[1]),
    .cnt_we  (cnt_we),
    .wdata   (wdata),
    .reload  (reload),
    .flag_clr(flag_clr),
    .count_o (count_o),
    .flag_o  (ovf_flag_o),
    .ext_o   (ext_o),
    .irq_o   (irq_o)
  );

  assign reload_o = reload;

  // R10: in external mode the internal tick alone never moves the count
  p_int_ignored_r10: assert property (@(posedge clk) disable iff (rst)
    (sel_ext && !pins_s[0] && cnt_we == '0) |=> $stable(count_o));

endmodule

// File: tb/updn_reload_timer_bench.sv
`timescale 1ns/1ps
module updn_reload_timer_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        int_tick = 1'b0, cnt_pin = 1'b1, dir_pin = 1'b1;
  logic        sel_ext = 1'b0, run = 1'b0, dn_en = 1'b0, flag_clr = 1'b0;
  logic [1:0]  cnt_we = '0, rld_we = '0;
  logic [15:0] wdata = '0;
  logic [15:0] count_o, reload_o;
  logic        ovf_flag_o, ext_o, irq_o;

  always #10 clk = ~clk;

  updn_reload_timer u_updn_reload_timer (
    .clk(clk), .rst(rst), .int_tick(int_tick), .cnt_pin(cnt_pin),
    .dir_pin(dir_pin), .sel_ext(sel_ext), .run(run), .dn_en(dn_en),
    .cnt_we(cnt_we), .rld_we(rld_we), .wdata(wdata), .flag_clr(flag_clr),
    .count_o(count_o), .reload_o(reload_o), .ovf_flag_o(ovf_flag_o),
    .ext_o(ext_o), .irq_o(irq_o)
  );

  typedef struct {
    string       req;
    logic [15:0] cnt;
    logic [15:0] rld;
    logic        flag;
    logic        ext;
    logic        irq;
  } item_t;

  item_t q[$];
  int checks = 0, fails = 0;

  // reference state
  logic [15:0] m_cnt = '0, m_rld = '0;
  logic        m_flag = 1'b0, m_ext = 1'b0, m_dir = 1'b1;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // driver: applies one cycle of stimulus and queues the expected result
  task automatic drive(input string req, input logic tk, input logic rn, input logic dn,
                       input logic [1:0] cwe, input logic [1:0] rwe,
                       input logic [15:0] wd, input logic clr);
    item_t it;
    logic  step, up, wrap;
    @(negedge clk);
    int_tick = tk; run = rn; dn_en = dn; cnt_we = cwe; rld_we = rwe;
    wdata = wd; flag_clr = clr;
    step = rn & tk & (cwe == 2'b00);
    up   = !dn || m_dir;
    wrap = step && (up ? (m_cnt == 16'hFFFF) : (m_cnt == m_rld));
    if (cwe != 2'b00) begin
      if (cwe[0]) m_cnt[7:0]  = wd[7:0];
      if (cwe[1]) m_cnt[15:8] = wd[15:8];
    end else if (wrap)  m_cnt = up ? m_rld : 16'hFFFF;
    else if (step)      m_cnt = up ? m_cnt + 16'd1 : m_cnt - 16'd1;
    if (rwe[0]) m_rld[7:0]  = wd[7:0];
    if (rwe[1]) m_rld[15:8] = wd[15:8];
    if (wrap) m_flag = 1'b1; else if (clr) m_flag = 1'b0;
    if (wrap && dn) m_ext = ~m_ext;
    it.req = req; it.cnt = m_cnt; it.rld = m_rld;
    it.flag = m_flag; it.ext = m_ext; it.irq = wrap;
    q.push_back(it);
  endtask

  task automatic ticks(input string req, input int n, input logic dn);
    for (int i = 0; i < n; i++) drive(req, 1'b1, 1'b1, dn, 2'b00, 2'b00, 16'h0, 1'b0);
  endtask

  task automatic set_dir(input logic v);
    @(negedge clk);
    dir_pin = v; m_dir = v;
    for (int i = 0; i < 3; i++) drive("R5", 1'b0, 1'b0, 1'b1, 2'b00, 2'b00, 16'h0, 1'b0);
  endtask

  // monitor: compares each queued item a quarter period after the edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        chk({it.req, " count"}, count_o, it.cnt);
        chk({it.req, " reload"}, reload_o, it.rld);
        chk({it.req, " flag/ext/irq"}, {13'd0, ovf_flag_o, ext_o, irq_o},
            {13'd0, it.flag, it.ext, it.irq});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 count", count_o, 16'h0);
    chk("R1 reload", reload_o, 16'h0);
    chk("R1 flag/ext/irq", {13'd0, ovf_flag_o, ext_o, irq_o}, 16'h0);

    // R9: reload lanes, one at a time
    drive("R9", 1'b0, 1'b0, 1'b0, 2'b00, 2'b01, 16'hAA34, 1'b0);
    drive("R9", 1'b0, 1'b0, 1'b0, 2'b00, 2'b10, 16'h12BB, 1'b0);
    // R8: a write beats a tick in the same cycle
    drive("R8", 1'b1, 1'b1, 1'b0, 2'b11, 2'b00, 16'hFFFD, 1'b0);
    // R3: count up and wrap to the reload value
    ticks("R3", 3, 1'b0);
    // R2: no tick, or no run, holds the count
    drive("R2", 1'b0, 1'b1, 1'b0, 2'b00, 2'b00, 16'h0, 1'b0);
    drive("R2", 1'b0, 1'b1, 1'b0, 2'b00, 2'b00, 16'h0, 1'b0);
    drive("R2", 1'b1, 1'b0, 1'b0, 2'b00, 2'b00, 16'h0, 1'b0);
    drive("R2", 1'b1, 1'b0, 1'b0, 2'b00, 2'b00, 16'h0, 1'b0);
    // R7: clear, then clear and wrap together
    drive("R7", 1'b0, 1'b0, 1'b0, 2'b00, 2'b00, 16'h0, 1'b1);
    drive("R7", 1'b0, 1'b0, 1'b0, 2'b11, 2'b00, 16'hFFFF, 1'b0);
    drive("R7", 1'b1, 1'b1, 1'b0, 2'b00, 2'b00, 16'h0, 1'b1);
    drive("R7", 1'b0, 1'b0, 1'b0, 2'b00, 2'b00, 16'h0, 1'b0);
    drive("R7", 1'b0, 1'b0, 1'b0, 2'b00, 2'b00, 16'h0, 1'b1);
    // R8: low lane only, tick discarded
    drive("R8", 1'b1, 1'b1, 1'b0, 2'b01, 2'b00, 16'h55EE, 1'b0);
    // R4: up/down mode counting up toggles the extension bit
    drive("R4", 1'b0, 1'b0, 1'b1, 2'b11, 2'b00, 16'hFFFE, 1'b0);
    ticks("R4", 3, 1'b1);
    drive("R4", 1'b0, 1'b0, 1'b1, 2'b00, 2'b00, 16'h0, 1'b1);
    // R5: count down to the reload floor
    set_dir(1'b0);
    drive("R5", 1'b0, 1'b0, 1'b1, 2'b11, 2'b00, 16'h1236, 1'b0);
    ticks("R5", 4, 1'b1);
    drive("R5", 1'b0, 1'b0, 1'b1, 2'b00, 2'b00, 16'h0, 1'b1);
    // R5: through zero is not a wrap
    drive("R5", 1'b0, 1'b0, 1'b1, 2'b11, 2'b00, 16'h0001, 1'b0);
    ticks("R5", 3, 1'b1);
    // R9: floor compare uses the old reload during a same-cycle write
    drive("R9", 1'b0, 1'b0, 1'b1, 2'b11, 2'b00, 16'h1234, 1'b0);
    drive("R9", 1'b1, 1'b1, 1'b1, 2'b00, 2'b11, 16'h0200, 1'b1);
    drive("R9", 1'b0, 1'b0, 1'b1, 2'b00, 2'b00, 16'h0, 1'b1);
    // R3: with up/down off the low direction pin is ignored, ext fixed
    drive("R3", 1'b0, 1'b0, 1'b0, 2'b11, 2'b00, 16'hFFFF, 1'b0);
    ticks("R3", 2, 1'b0);

    // R10: external falling edges only, internal tick ignored
    drive("R10", 1'b0, 1'b0, 1'b0, 2'b11, 2'b00, 16'h0010, 1'b1);
    @(negedge clk);
    dir_pin = 1'b1; sel_ext = 1'b1; run = 1'b1; int_tick = 1'b1;
    cnt_we = '0; rld_we = '0; flag_clr = 1'b0;
    repeat (6) @(negedge clk);
    chk("R10 no count on steady pin", count_o, 16'h0010);
    for (int p = 0; p < 5; p++) begin
      cnt_pin = 1'b0; repeat (4) @(negedge clk);
      cnt_pin = 1'b1; repeat (4) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    chk("R10 five falls", count_o, 16'h0015);
    run = 1'b0;
    cnt_pin = 1'b0; repeat (4) @(negedge clk);
    cnt_pin = 1'b1; repeat (4) @(negedge clk);
    chk("R2 external fall while stopped", count_o, 16'h0015);
    sel_ext = 1'b0; int_tick = 1'b0;
    repeat (3) @(negedge clk);
    summary();
  end

endmodule